// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a minimal synchronous processor that keeps one working register (the accumulator) and a program counter. It is attached to a single-ported word memory and performs exactly one memory access per clock cycle. Every instruction takes two cycles. In the first cycle the core places the program counter on the address bus and captures the instruction word. In the second cycle it places the instruction's address field on the bus and either combines the returned word with the accumulator or writes the accumulator to that location.

The memory is expected to return read data in the same cycle that the address is presented, and to commit a write at the clock edge that ends a cycle with the write enable high. A 16-bit instruction word holds a 4-bit operation code in bits [15:12] and a 12-bit operand address in bits [11:0]. The core stops for good on a halt instruction and stays stopped until reset.

Top module: `accum_core`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the first cycle after it, the program counter is 100 and the accumulator is 0. During reset the address bus shows 100, the write enable is low and `halted` is low.
- R2: In the fetch cycle of each instruction, the address bus carries the program counter, the write enable is low, and the word on `mem_rdata` is captured as the instruction.
- R3: In the second cycle, the address bus carries bits [11:0] of the captured instruction. The operation code is bits [15:12].
- R4: Operation code 3 (add) sets the accumulator to the old value plus the operand, modulo 2^16. For example, 0 plus 40 gives 40.
- R5: Operation code 4 (multiply) sets the accumulator to the low 16 bits of the product of the accumulator and the operand.
- R6: Operation code 1 (load) replaces the accumulator with the operand.
- R7: Operation code 2 (store) raises the write enable in the second cycle only, drives the accumulator on `mem_wdata`, and leaves the accumulator unchanged.
- R8: Every instruction except halt takes exactly two cycles and then adds one to the program counter, so the instruction at address 100 is followed by the one at 101.
- R9: Operation code 15 (halt) raises `halted` from the next cycle on. From then until reset the program counter is frozen at the halt instruction's address and sits on the address bus. No further fetches or writes take place.
- R10: Any other operation code leaves the accumulator unchanged and writes nothing, and the program counter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address for the current access |
| mem_rdata | input | 16 | Word read from `mem_addr`, valid within the same cycle |
| mem_wdata | output | 16 | Data to write, which is the accumulator |
| mem_we | output | 1 | Write strobe, committed at the clock edge |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the core with its default parameters: 16-bit words, a 12-bit address field and a reset program counter of 100. It backs the core with a full 4096-word memory that has a combinational read. These widths make 16-bit wrap-around reachable with a small program: a multiply whose product needs 20 bits, and an add of 0xFFFF. A reference model inside the bench predicts the address, write enable and write data for every cycle. The program includes a load of a word the program itself stored, an undefined operation code, and a halt followed by idle cycles. A second reset after the halt then shows that the core restarts cleanly from 100.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_LOAD  = 4'h1,
    OPC_STORE = 4'h2,
    OPC_ADD   = 4'h3,
    OPC_MUL   = 4'h4,
    OPC_HALT  = 4'hF
  } opcode_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/accum_seq.sv
module accum_seq
  import accum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_op,
  output logic fetch_cyc,
  output logic exec_cyc,
  output logic halted
);
  phase_e phase_q;
  logic   halted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FETCH;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (phase_q == PH_FETCH) begin
        phase_q <= PH_EXEC;
      end else begin
        phase_q <= PH_FETCH;
        if (halt_op) halted_q <= 1'b1;
      end
    end
  end

  assign fetch_cyc = (phase_q == PH_FETCH) && !halted_q;
  assign exec_cyc  = (phase_q == PH_EXEC) && !halted_q;
  assign halted    = halted_q;

  // R2: a fetch is always followed by the operand access
  a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
    fetch_cyc |=> exec_cyc);

  // R8: the operand access is followed by a new fetch unless the core stopped
  a_r8_exec_then_fetch: assert property (@(posedge clk) disable iff (rst)
    exec_cyc |=> (fetch_cyc || halted));

  // R9: once stopped, no further activity until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !fetch_cyc && !exec_cyc));
endmodule

// File: rtl/accum_dp.sv
module accum_dp
  import accum_pkg::*;
#(
  parameter int DW       = 16,
  parameter int RESET_PC = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_cyc,
  input  logic          exec_cyc,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-OPC_W-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halt_op
);
  localparam int AW = DW - OPC_W;

  logic [DW-1:0]    ir_q;
  logic [DW-1:0]    acc_q;
  logic [AW-1:0]    pc_q;
  logic [OPC_W-1:0] opc;
  logic [AW-1:0]    opnd_addr;
  logic             acc_write;

  function automatic logic [DW-1:0] acc_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] acc_prod_lo(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    return p[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] next_acc(input logic [OPC_W-1:0] op,
                                              input logic [DW-1:0] acc,
                                              input logic [DW-1:0] opnd);
    case (op)
      OPC_LOAD: return opnd;
      OPC_ADD:  return acc_sum(acc, opnd);
      OPC_MUL:  return acc_prod_lo(acc, opnd);
      default:  return acc;
    endcase
  endfunction

  assign opc       = ir_q[DW-1 -: OPC_W];
  assign opnd_addr = ir_q[AW-1:0];
  assign halt_op   = exec_cyc && (opc == OPC_HALT);
  assign acc_write = exec_cyc && ((opc == OPC_LOAD) || (opc == OPC_ADD) || (opc == OPC_MUL));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= AW'(RESET_PC);
      acc_q <= '0;
      ir_q  <= '0;
    end else begin
      if (fetch_cyc) ir_q <= mem_rdata;
      if (exec_cyc) begin
        acc_q <= next_acc(opc, acc_q, mem_rdata);
        if (opc != OPC_HALT) pc_q <= pc_q + AW'(1);
      end
    end
  end

  assign mem_addr  = exec_cyc ? opnd_addr : pc_q;
  assign mem_we    = exec_cyc && (opc == OPC_STORE);
  assign mem_wdata = acc_q;

  // R1: state right after reset
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == AW'(RESET_PC) && acc_q == '0));

  // R7: a write leaves the accumulator untouched
  a_r7_store_holds_acc: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (acc_q == $past(acc_q)));

  // R8: completed non-halt instruction steps the program counter
  a_r8_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (exec_cyc && !halt_op) |=> (pc_q == $past(pc_q) + AW'(1)));

  // R9: halt freezes the program counter
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halt_op |=> $stable(pc_q));

  // R10: operations that do not target the accumulator leave it alone
  a_r10_acc_untouched: assert property (@(posedge clk) disable iff (rst)
    (exec_cyc && !acc_write) |=> $stable(acc_q));
endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int DW       = 16,
  parameter int RESET_PC = 100
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [DW-OPC_W-1:0]   mem_addr,
  input  logic [DW-1:0]         mem_rdata,
  output logic [DW-1:0]         mem_wdata,
  output logic                  mem_we,
  output logic                  halted
);
  logic fetch_cyc;
  logic exec_cyc;
  logic halt_op;

  accum_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .halt_op   (halt_op),
    .fetch_cyc (fetch_cyc),
    .exec_cyc  (exec_cyc),
    .halted    (halted)
  );

  accum_dp #(.DW(DW), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .fetch_cyc (fetch_cyc),
    .exec_cyc  (exec_cyc),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halt_op   (halt_op)
  );

  // R7: writes only happen while the core is running
  a_r7_no_write_when_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
endmodule

// File: tb/accum_core_tb_top.sv
module accum_core_tb_top;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int PC0 = 100;

  typedef struct {
    logic [AW-1:0] addr;
    logic          we;
    logic [DW-1:0] wdata;
    logic          halt;
    string         tag;
  } bus_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          halted;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  bus_item_t     expq[$];
  bit            mon_en = 1'b0;
  int            checks = 0;
  int            failures = 0;

  always #4 clk = ~clk;

  accum_core #(.DW(DW), .RESET_PC(PC0)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [DW-1:0] ins(input int op, input int a);
    return {4'(op), 12'(a)};
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: runs an independent model over a copy of memory and queues bus cycles
  task automatic drive_program();
    logic [DW-1:0] m [0:(1<<AW)-1];
    logic [AW-1:0] pc;
    logic [DW-1:0] acc, w;
    int op;
    logic [AW-1:0] a;
    string last;
    for (int i = 0; i < (1<<AW); i++) m[i] = mem[i];
    pc = AW'(PC0); acc = '0; last = "R1";
    for (int n = 0; n < 100; n++) begin
      w  = m[pc];
      op = int'(w[15:12]);
      a  = w[11:0];
      expq.push_back('{pc, 1'b0, '0, 1'b0, "R2 R8"});
      if (op == 2) expq.push_back('{a, 1'b1, acc, 1'b0, {"R7 ", last}});
      else         expq.push_back('{a, 1'b0, '0, 1'b0, "R3"});
      case (op)
        1: begin acc = m[a]; last = "R6"; end
        2: m[a] = acc;
        3: begin acc = DW'((32'(acc) + 32'(m[a])) % 32'h10000); last = "R4"; end
        4: begin acc = DW'((32'(acc) * 32'(m[a])) & 32'hFFFF); last = "R5"; end
        15: ;
        default: last = "R10";
      endcase
      if (op == 15) begin
        for (int k = 0; k < 6; k++) expq.push_back('{pc, 1'b0, '0, 1'b1, "R9"});
        break;
      end
      pc = pc + AW'(1);
    end
  endtask

  // monitor: compares each cycle against the queued expectation
  always @(negedge clk) begin
    #1;
    if (mon_en && expq.size() > 0) begin
      bus_item_t e;
      e = expq.pop_front();
      check(e.tag, "addr", longint'(mem_addr), longint'(e.addr));
      check(e.tag, "we", longint'(mem_we), longint'(e.we));
      check(e.tag, "halted", longint'(halted), longint'(e.halt));
      if (e.we) check(e.tag, "wdata", longint'(mem_wdata), longint'(e.wdata));
    end
  end

  task automatic reset_and_check();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset addr", longint'(mem_addr), PC0);
    check("R1", "reset we", longint'(mem_we), 0);
    check("R1", "reset halted", longint'(halted), 0);
  endtask

  task automatic run_once();
    drive_program();
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    while (expq.size() > 0) @(posedge clk);
    @(negedge clk);
    #2;
    mon_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    mem[200] = 16'd7;   mem[201] = 16'd40;  mem[202] = 16'd3;
    mem[203] = 16'h1000; mem[204] = 16'hFFFF; mem[210] = 16'd40;
    mem[100] = ins(3, 210);  // R4: 0 + 40
    mem[101] = ins(2, 306);
    mem[102] = ins(1, 200);  // R6
    mem[103] = ins(3, 201);
    mem[104] = ins(2, 300);
    mem[105] = ins(4, 202);  // R5
    mem[106] = ins(2, 301);
    mem[107] = ins(4, 203);  // R5 wrap
    mem[108] = ins(2, 302);
    mem[109] = ins(3, 204);  // R4 wrap
    mem[110] = ins(2, 303);
    mem[111] = ins(0, 205);  // R10
    mem[112] = ins(7, 206);  // R10
    mem[113] = ins(2, 304);
    mem[114] = ins(1, 300);  // reads back stored word
    mem[115] = ins(2, 305);
    mem[116] = ins(15, 0);   // R9
    reset_and_check();
    run_once();
    check("R7", "stored 306", longint'(mem[306]), 40);
    check("R5", "stored 302", longint'(mem[302]), 16'hD000);
    check("R4", "stored 303", longint'(mem[303]), 16'hCFFF);
    check("R6", "stored 305", longint'(mem[305]), 47);
    reset_and_check();
    run_once();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule